// File: doc/BRIEF.md
# Error trap entry sequencer

This block carries a processor core through the entry into an asynchronous error trap. It receives the current trap level, a flag that tells whether the core already runs in RED mode, the trap base address, the trap type, the reset vector base, and the processor state word, PC and NPC as they stood just before the trap. Each of the last three comes with an uncorrectable-error tag. After one request it works through three fixed steps in order. First it decides the new core state, then it forms the trap target address, and last it raises the trap level and commits the results.

The new trap level indexes a small trap stack with one entry per level. The old state word, PC and NPC are written into that entry together with their error tags. A read port lets the rest of the core fetch any entry by level. When the trap level is already at its maximum, the core drops into a sticky error state and the trap is abandoned: no register changes, and no completion pulse is raised. Only a reset leaves that state.

Top module: `err_trap_seq`

## Requirements
- R1: A request whose trap level is at least MAXTL (default 5) puts core_state into error (2'b10) one cycle after acceptance. trap_done never pulses for it, and new_pc, new_npc, new_tl and the trap stack keep their values. core_state then stays at error and every later request is ignored until reset.
- R2: A request taken in execution mode (red_mode=0) with trap level MAXTL-1 sets core_state to RED (2'b01).
- R3: A request below MAXTL leaves core_state at RED (2'b01) when red_mode=1. It leaves core_state at execution (2'b00) when red_mode=0 and the level is below MAXTL-1.
- R4: In execution state the target address is built from high to low as follows: tbase[63:15], then one bit that is 1 when the incoming trap level is nonzero, then ttype[8:0], then five zero bits.
- R5: In RED state the target address is rvec plus 0xA0.
- R6: On completion new_tl equals the incoming trap level plus one.
- R7: On completion the trap-stack entry read at rd_lvl equal to the new trap level returns the pre-trap state word, PC and NPC with their uncorrectable-error tags unchanged.
- R8: On completion new_pc equals the target address and new_npc equals the target address plus 4.
- R9: A request is accepted only while the sequencer is idle. Requests that arrive during a sequence are ignored, and so are their operand values. trap_done is a one-cycle pulse that is high in the cycle after the third rising edge following the accepting edge.
- R10: After reset core_state is 2'b00, trap_done is 0, new_tl is 0 and new_pc and new_npc are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Error trap request |
| cur_tl | input | 3 | Trap level before the trap |
| red_mode | input | 1 | 1 when the core already runs in RED mode |
| tbase | input | 64 | Trap base address |
| ttype | input | 9 | Trap type |
| rvec | input | 64 | Reset vector base |
| pst_in | input | 16 | Processor state word before the trap |
| pst_ue | input | 1 | Uncorrectable-error tag of pst_in |
| pc_in | input | 64 | PC before the trap |
| pc_ue | input | 1 | Uncorrectable-error tag of pc_in |
| npc_in | input | 64 | NPC before the trap |
| npc_ue | input | 1 | Uncorrectable-error tag of npc_in |
| rd_lvl | input | 3 | Trap-stack level to read (1 to MAXTL) |
| core_state | output | 2 | 00 execution, 01 RED, 10 error |
| new_pc | output | 64 | PC after trap entry |
| new_npc | output | 64 | NPC after trap entry |
| new_tl | output | 3 | Trap level after trap entry |
| trap_done | output | 1 | One-cycle completion pulse |
| rd_pst | output | 16 | Saved state word at rd_lvl |
| rd_pst_ue | output | 1 | Saved state word error tag |
| rd_pc | output | 64 | Saved PC at rd_lvl |
| rd_pc_ue | output | 1 | Saved PC error tag |
| rd_npc | output | 64 | Saved NPC at rd_lvl |
| rd_npc_ue | output | 1 | Saved NPC error tag |

## Verification
The assertions assume that the incoming trap level never exceeds MAXTL. They also assume that the operand inputs are meaningful only in the cycle where a request is accepted. The random stimulus draws trap levels from 0 to MAXTL-1 and leans toward MAXTL-1 so that RED escalation shows up often. Requests are pulsed only while idle, except for deliberate pokes during a sequence that carry altered operands. A single directed request at MAXTL comes last, because the error state it enters is sticky.

// File: rtl/err_trap_seq.sv
module err_trap_seq #(
  parameter int MAXTL = 5,
  parameter int PSW   = 16,
  parameter int AW    = 64,
  parameter int TTW   = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trap_req,
  input  logic [$clog2(MAXTL+1)-1:0] cur_tl,
  input  logic                     red_mode,
  input  logic [AW-1:0]            tbase,
  input  logic [TTW-1:0]           ttype,
  input  logic [AW-1:0]            rvec,
  input  logic [PSW-1:0]           pst_in,
  input  logic                     pst_ue,
  input  logic [AW-1:0]            pc_in,
  input  logic                     pc_ue,
  input  logic [AW-1:0]            npc_in,
  input  logic                     npc_ue,
  input  logic [$clog2(MAXTL+1)-1:0] rd_lvl,
  output logic [1:0]               core_state,
  output logic [AW-1:0]            new_pc,
  output logic [AW-1:0]            new_npc,
  output logic [$clog2(MAXTL+1)-1:0] new_tl,
  output logic                     trap_done,
  output logic [PSW-1:0]           rd_pst,
  output logic                     rd_pst_ue,
  output logic [AW-1:0]            rd_pc,
  output logic                     rd_pc_ue,
  output logic [AW-1:0]            rd_npc,
  output logic                     rd_npc_ue
);
  localparam int TLW = $clog2(MAXTL+1);
  localparam int LOW = TTW + 6;
  localparam logic [1:0] ST_EXEC = 2'b00, ST_RED = 2'b01, ST_ERR = 2'b10;

  typedef enum logic [2:0] {P_IDLE, P_DEC, P_ADDR, P_COM, P_HALT} phase_t;
  phase_t phase;

  logic [TLW-1:0]    l_tl;
  logic              l_red;
  logic [AW-1:LOW]   l_tba;
  logic [TTW-1:0]    l_tt;
  logic [AW-1:0]     l_rvec, l_pc, l_npc, tgt;
  logic [PSW-1:0]    l_ps;
  logic              l_psue, l_pcue, l_npcue;

  logic [PSW-1:0]    stk_ps   [MAXTL];
  logic [AW-1:0]     stk_pc   [MAXTL];
  logic [AW-1:0]     stk_npc  [MAXTL];
  logic [2:0]        stk_ue   [MAXTL];

  logic unused_tbase_low;
  assign unused_tbase_low = ^tbase[LOW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      core_state <= ST_EXEC;
      trap_done <= 1'b0;
      new_pc <= '0;
      new_npc <= '0;
      new_tl <= '0;
      tgt <= '0;
      l_tl <= '0; l_red <= 1'b0; l_tba <= '0; l_tt <= '0; l_rvec <= '0;
      l_ps <= '0; l_psue <= 1'b0; l_pc <= '0; l_pcue <= 1'b0;
      l_npc <= '0; l_npcue <= 1'b0;
      for (int i = 0; i < MAXTL; i++) begin
        stk_ps[i] <= '0; stk_pc[i] <= '0; stk_npc[i] <= '0; stk_ue[i] <= '0;
      end
    end else begin
      trap_done <= 1'b0;
      case (phase)
        P_IDLE: if (trap_req) begin
          l_tl <= cur_tl; l_red <= red_mode; l_tba <= tbase[AW-1:LOW];
          l_tt <= ttype; l_rvec <= rvec;
          l_ps <= pst_in; l_psue <= pst_ue;
          l_pc <= pc_in;  l_pcue <= pc_ue;
          l_npc <= npc_in; l_npcue <= npc_ue;
          phase <= P_DEC;
        end
        P_DEC: begin
          if (l_tl >= TLW'(MAXTL)) begin
            core_state <= ST_ERR;
            phase <= P_HALT;
          end else begin
            if (l_red || l_tl == TLW'(MAXTL-1)) core_state <= ST_RED;
            else                                core_state <= ST_EXEC;
            phase <= P_ADDR;
          end
        end
        P_ADDR: begin
          if (core_state == ST_RED) tgt <= l_rvec + AW'(12'hA0);
          else                      tgt <= {l_tba, (l_tl != '0), l_tt, 5'b0};
          phase <= P_COM;
        end
        P_COM: begin
          new_tl  <= l_tl + TLW'(1);
          new_pc  <= tgt;
          new_npc <= tgt + AW'(4);
          stk_ps[l_tl]  <= l_ps;
          stk_pc[l_tl]  <= l_pc;
          stk_npc[l_tl] <= l_npc;
          stk_ue[l_tl]  <= {l_psue, l_pcue, l_npcue};
          trap_done <= 1'b1;
          phase <= P_IDLE;
        end
        default: phase <= P_HALT;
      endcase
    end
  end

  logic           rd_ok;
  logic [TLW-1:0] rd_idx;
  assign rd_ok  = (rd_lvl != '0) && (rd_lvl <= TLW'(MAXTL));
  assign rd_idx = rd_ok ? rd_lvl - TLW'(1) : '0;
  assign rd_pst    = rd_ok ? stk_ps[rd_idx]     : '0;
  assign rd_pc     = rd_ok ? stk_pc[rd_idx]     : '0;
  assign rd_npc    = rd_ok ? stk_npc[rd_idx]    : '0;
  assign rd_pst_ue = rd_ok ? stk_ue[rd_idx][2]  : 1'b0;
  assign rd_pc_ue  = rd_ok ? stk_ue[rd_idx][1]  : 1'b0;
  assign rd_npc_ue = rd_ok ? stk_ue[rd_idx][0]  : 1'b0;

  assert_err_at_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_DEC && l_tl >= TLW'(MAXTL)) |=> (core_state == ST_ERR && phase == P_HALT));
  assert_halt_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_HALT) |=> (phase == P_HALT && !trap_done && $stable(new_tl) && $stable(new_pc)));
  assert_red_escalate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_DEC && !l_red && l_tl == TLW'(MAXTL-1)) |=> core_state == ST_RED);
  assert_red_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_done && core_state == ST_RED) |-> new_pc == l_rvec + AW'(12'hA0));
  assert_tl_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_done |-> new_tl == l_tl + TLW'(1));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_done |=> !trap_done);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_DEC || phase == P_ADDR || phase == P_COM) |=> ($stable(l_tl) && $stable(l_pc) && $stable(l_red)));
endmodule

// File: tb/sim_err_trap_seq.sv
module sim_err_trap_seq;
  localparam int MAXTL = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic trap_req = 0, red_mode = 0, pst_ue = 0, pc_ue = 0, npc_ue = 0;
  logic [2:0] cur_tl = 0, rd_lvl = 0, new_tl;
  logic [63:0] tbase = 0, rvec = 0, pc_in = 0, npc_in = 0, new_pc, new_npc, rd_pc, rd_npc;
  logic [8:0] ttype = 0;
  logic [15:0] pst_in = 0, rd_pst;
  logic [1:0] core_state;
  logic trap_done, rd_pst_ue, rd_pc_ue, rd_npc_ue;

  int checks = 0, fails = 0;
  bit finished = 0;

  err_trap_seq u0 (.clk(clk), .rst_n(rst_n), .trap_req(trap_req), .cur_tl(cur_tl),
    .red_mode(red_mode), .tbase(tbase), .ttype(ttype), .rvec(rvec), .pst_in(pst_in),
    .pst_ue(pst_ue), .pc_in(pc_in), .pc_ue(pc_ue), .npc_in(npc_in), .npc_ue(npc_ue),
    .rd_lvl(rd_lvl), .core_state(core_state), .new_pc(new_pc), .new_npc(new_npc),
    .new_tl(new_tl), .trap_done(trap_done), .rd_pst(rd_pst), .rd_pst_ue(rd_pst_ue),
    .rd_pc(rd_pc), .rd_pc_ue(rd_pc_ue), .rd_npc(rd_npc), .rd_npc_ue(rd_npc_ue));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_tgt(input logic [2:0] tl, input bit red,
      input logic [63:0] tb, input logic [8:0] tt, input logic [63:0] rv);
    if (red) return rv + 64'hA0;
    return {tb[63:15], (tl != 0), tt, 5'b00000};
  endfunction

  function automatic logic [1:0] exp_state(input logic [2:0] tl, input bit red);
    if (red || tl == MAXTL-1) return 2'b01;
    return 2'b00;
  endfunction

  task automatic run_trap(input logic [2:0] tl, input bit red, input logic [63:0] tb,
      input logic [8:0] tt, input logic [63:0] rv, input logic [15:0] ps, input bit psu,
      input logic [63:0] pc, input bit pcu, input logic [63:0] npc, input bit npcu, input bit poke);
    logic [1:0] es;
    logic [63:0] et;
    es = exp_state(tl, red);
    et = exp_tgt(tl, es == 2'b01, tb, tt, rv);
    @(negedge clk);
    cur_tl = tl; red_mode = red; tbase = tb; ttype = tt; rvec = rv;
    pst_in = ps; pst_ue = psu; pc_in = pc; pc_ue = pcu; npc_in = npc; npc_ue = npcu;
    trap_req = 1;
    @(negedge clk);
    trap_req = 0;
    if (poke) begin
      cur_tl = 3'd0; red_mode = ~red; pc_in = ~pc; npc_in = ~npc; ttype = ~tt; trap_req = 1;
    end
    @(negedge clk);
    chk(trap_done == 0, "R9 early done", 64'(trap_done), 0);
    @(negedge clk);
    chk(trap_done == 0, "R9 early done", 64'(trap_done), 0);
    trap_req = 0;
    @(negedge clk);
    chk(trap_done == 1, "R9 done timing", 64'(trap_done), 1);
    chk(core_state == es, (red ? "R3 state red" : "R2/R3 state"), 64'(core_state), 64'(es));
    chk(new_pc == et, (es == 2'b01 ? "R5 red target" : "R4 exec target"), new_pc, et);
    chk(new_npc == et + 4, "R8 npc", new_npc, et + 4);
    chk(new_tl == tl + 3'd1, "R6 tl inc", 64'(new_tl), 64'(tl + 3'd1));
    rd_lvl = tl + 3'd1;
    #1;
    chk(rd_pst == ps && rd_pst_ue == psu, "R7 saved state", {47'b0, rd_pst_ue, rd_pst}, {47'b0, psu, ps});
    chk(rd_pc == pc && rd_pc_ue == pcu, "R7 saved pc", rd_pc, pc);
    chk(rd_npc == npc && rd_npc_ue == npcu, "R7 saved npc", rd_npc, npc);
    @(negedge clk);
    chk(trap_done == 0, "R9 one-cycle pulse", 64'(trap_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] tl;
    logic [2:0] keep_tl;
    logic [63:0] keep_pc;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(core_state == 2'b00, "R10 reset state", 64'(core_state), 0);
    chk(trap_done == 0, "R10 reset done", 64'(trap_done), 0);
    chk(new_tl == 0 && new_pc == 0 && new_npc == 0, "R10 reset regs", new_pc, 0);

    run_trap(3'd0, 0, 64'hFFFF_0000_1234_8000, 9'h1A3, 64'h0000_0000_F000_0000,
             16'hBEEF, 0, 64'h1000, 0, 64'h1004, 0, 0);
    run_trap(3'd1, 0, 64'h0123_4567_89AB_FFFF, 9'h0FF, 64'h10, 16'h0001, 1, 64'h2000, 0, 64'h2004, 1, 0);
    run_trap(3'(MAXTL-1), 0, 64'hAAAA_5555_0000_0000, 9'h040, 64'hFFFF_FFFF_FFFF_FF80,
             16'h7777, 1, 64'h3000, 1, 64'h3004, 1, 0);
    run_trap(3'd2, 1, 64'h8000_0000_0000_0000, 9'h1FF, 64'h4000, 16'h1234, 0, 64'h5000, 1, 64'h5004, 0, 0);
    run_trap(3'd3, 0, 64'h0000_0000_0001_0000, 9'h055, 64'h9000, 16'h4321, 0, 64'h6000, 0, 64'h6004, 0, 1);

    for (int n = 0; n < 150; n++) begin
      tl = ($urandom % 3 == 0) ? 3'(MAXTL-1) : 3'($urandom % MAXTL);
      run_trap(tl, 1'($urandom), {$urandom, $urandom}, 9'($urandom), {$urandom, $urandom},
               16'($urandom), 1'($urandom), {$urandom, $urandom}, 1'($urandom),
               {$urandom, $urandom}, 1'($urandom), 1'($urandom % 4 == 0));
    end

    keep_tl = new_tl;
    keep_pc = new_pc;
    @(negedge clk);
    cur_tl = 3'(MAXTL); red_mode = 0; pc_in = 64'hDEAD; trap_req = 1;
    @(negedge clk);
    trap_req = 0;
    @(negedge clk);
    chk(core_state == 2'b10, "R1 error state", 64'(core_state), 2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(trap_done == 0, "R1 no done in error", 64'(trap_done), 0);
    end
    chk(new_tl == keep_tl, "R1 tl unchanged", 64'(new_tl), 64'(keep_tl));
    chk(new_pc == keep_pc, "R1 pc unchanged", new_pc, keep_pc);
    cur_tl = 3'd0; red_mode = 0; trap_req = 1;
    @(negedge clk);
    trap_req = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(trap_done == 0, "R1 request ignored", 64'(trap_done), 0);
    end
    chk(core_state == 2'b10, "R1 error sticky", 64'(core_state), 2);
    chk(new_tl == keep_tl, "R1 tl still unchanged", 64'(new_tl), 64'(keep_tl));

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule